// File: doc/BRIEF.md
# 1-Wire Reset and Presence Controller

This block is the command front end of a 1-Wire bus master. A host presents one command byte at a time on a simple valid/code interface. Two codes are understood. One is a global master reset that aborts bus activity and returns status, mode bits and timing registers to their power-up state. The other runs a reset/presence-detect cycle on an open-drain bus line. Every other code is refused.

During a reset/presence cycle the controller pulls the line low for the configured low time, releases it, and then samples it twice. One sample, at a configurable offset after release, reports whether a slave answered with a presence pulse. The other, at a second offset, reports whether the line is shorted. The busy flag stays up for twice the low time. All durations are counts of system clock cycles. The host sets them, together with four mode bits, through a small write port. That port is locked while the bus is busy.

After a master reset, the reset flag reads 1 until a reset/presence cycle is accepted. This tells the host that the bus still needs a reset pulse before any other traffic.

Top module: `owm_rstpd_ctrl`

## Requirements
- R1: After the `rst` input, `status` reads 8'h08, `mode_o` reads 0, the three timing outputs hold their parameter defaults, and `line_drive_low` and `line_pu` are 0. The `status` fields are: bit0 busy, bit1 presence, bit2 short, bit3 reset flag, bits 7:4 always 0.
- R2: Code 8'hF0 is always acknowledged and takes effect at the next clock edge. It stops any running cycle (busy 0, line released), sets the reset flag, clears presence, short and all mode bits, and restores the timing registers to their defaults.
- R3: Code 8'hB4 received while busy is 0 is acknowledged: `cmd_ack` is 1 in the cycle after the code. Busy is then 1 for exactly 2·L cycles starting in that same cycle, and the reset flag is cleared. L is the effective low time.
- R4: In an accepted cycle, `line_drive_low` is 1 for the first L of the busy cycles and 0 afterwards.
- R5: Let E0 be the edge that accepts the command. At edge E0+L+P the presence bit is loaded with 1 if `line_in` is low and 0 if it is high. P is the effective presence offset.
- R6: At edge E0+L+S the short bit is loaded the same way from `line_in`. S is the effective short offset.
- R7: Code 8'hB4 received while busy is 1 is not acknowledged and leaves the running cycle's timing unchanged.
- R8: Any code other than 8'hF0 and 8'hB4 is not acknowledged and changes no state.
- R9: A write with `cfg_we` goes to one of four registers selected by `cfg_addr`: 0 = mode bits (`cfg_wdata[3:0]`), 1 = low time, 2 = presence offset, 3 = short offset. The register is read back on its output in the next cycle. Writes made while busy is 1 are ignored.
- R10: When mode bit 0 (fast) is set, the effective L, P and S are the register values shifted right by FAST_SHIFT, with a floor of 1. When the bit is clear they equal the register values.
- R11: When mode bit 1 (active pull-up) is set, `line_pu` is 1 during the busy cycles that follow the low phase. It is 0 at all other times, and always 0 while the bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_code | input | 8 | Command byte |
| cmd_ack | output | 1 | Command of the previous cycle accepted |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | TW | Configuration write data |
| status | output | 8 | Status flags (busy, presence, short, reset) |
| mode_o | output | 4 | Mode bits: fast, active pull-up, two stored bits |
| t_low_o | output | TW | Low time register |
| t_pres_o | output | TW | Presence sample offset register |
| t_short_o | output | TW | Short sample offset register |
| line_drive_low | output | 1 | Open-drain pull-down enable |
| line_pu | output | 1 | Active pull-up enable |
| line_in | input | 1 | Sampled bus line level |

## Verification
The bench uses TW = 8, FAST_SHIFT = 2 and default timings of 24, 6 and 3 cycles. With these values a full cycle, including aborts and refused commands injected at any chosen busy cycle, takes a few dozen clocks. That lets every cycle of the busy, drive and pull-up windows be compared exactly against expectations. A modelled slave pulls the line in a chosen window, so each sample instant is tested on both sides of its boundary. The shift of 2 makes fast mode visibly change L, P and S, and the register defaults are small enough that the restore after a master reset can be read back directly.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam logic [7:0] CMD_MASTER_RST = 8'hF0;
    localparam logic [7:0] CMD_RESET_PD   = 8'hB4;

    typedef enum logic [1:0] {
        CFG_MODE   = 2'd0,
        CFG_TLOW   = 2'd1,
        CFG_TPRES  = 2'd2,
        CFG_TSHORT = 2'd3
    } cfg_addr_e;

    typedef struct packed {
        logic spu;
        logic pdn;
        logic apu;
        logic fast;
    } mode_t;

    typedef struct packed {
        logic [3:0] rsv;
        logic       rst_f;
        logic       short_f;
        logic       pres_f;
        logic       busy;
    } status_t;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_MRST  = 2'd1,
        ACT_PULSE = 2'd2
    } act_e;

    // effective duration: optionally scaled down, never below one cycle
    function automatic logic [31:0] eff_time(input logic [31:0] t, input logic fast,
                                             input int unsigned sh);
        logic [31:0] v;
        v = fast ? (t >> sh) : t;
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/owm_cmd_dec.sv
module owm_cmd_dec
    import owm_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       busy,
    output act_e       act
);
    always_comb begin
        act = ACT_NONE;
        if (cmd_valid) begin
            if (cmd_code == CMD_MASTER_RST)
                act = ACT_MRST;
            else if (cmd_code == CMD_RESET_PD && !busy)
                act = ACT_PULSE;
        end
    end
endmodule

// File: rtl/owm_cfg_regs.sv
module owm_cfg_regs
    import owm_pkg::*;
#(
    parameter int TW        = 8,
    parameter int DEF_LOW   = 24,
    parameter int DEF_PRES  = 6,
    parameter int DEF_SHORT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          busy,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [TW-1:0] wdata,
    output mode_t         mode,
    output logic [TW-1:0] t_low,
    output logic [TW-1:0] t_pres,
    output logic [TW-1:0] t_short
);
    localparam logic [TW-1:0] RST_LOW   = TW'(DEF_LOW);
    localparam logic [TW-1:0] RST_PRES  = TW'(DEF_PRES);
    localparam logic [TW-1:0] RST_SHORT = TW'(DEF_SHORT);

    cfg_addr_e sel;
    assign sel = cfg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mode    <= '0;
            t_low   <= RST_LOW;
            t_pres  <= RST_PRES;
            t_short <= RST_SHORT;
        end else if (we && !busy) begin
            case (sel)
                CFG_MODE:   mode    <= mode_t'(wdata[3:0]);
                CFG_TLOW:   t_low   <= wdata;
                CFG_TPRES:  t_pres  <= wdata;
                CFG_TSHORT: t_short <= wdata;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/owm_pulse_seq.sv
module owm_pulse_seq
    import owm_pkg::*;
#(
    parameter int          TW         = 8,
    parameter int unsigned FAST_SHIFT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          start,
    input  logic          fast,
    input  logic          apu,
    input  logic [TW-1:0] t_low,
    input  logic [TW-1:0] t_pres,
    input  logic [TW-1:0] t_short,
    output logic          busy,
    output logic          drive_low,
    output logic          pu_en,
    output logic          pres_stb,
    output logic          short_stb
);
    localparam int CW = TW + 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] l_eff, p_eff, s_eff, end_cnt;

    // registers are write-locked while busy, so these stay steady for a cycle
    assign l_eff   = CW'(eff_time(32'(t_low),   fast, FAST_SHIFT));
    assign p_eff   = CW'(eff_time(32'(t_pres),  fast, FAST_SHIFT));
    assign s_eff   = CW'(eff_time(32'(t_short), fast, FAST_SHIFT));
    assign end_cnt = l_eff << 1;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(1);
        end else if (busy) begin
            if (cnt == end_cnt) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign drive_low = busy && (cnt <= l_eff);
    assign pu_en     = busy && apu && (cnt > l_eff);
    assign pres_stb  = busy && (cnt == l_eff + p_eff);
    assign short_stb = busy && (cnt == l_eff + s_eff);
endmodule

// File: rtl/owm_rstpd_ctrl.sv
module owm_rstpd_ctrl
    import owm_pkg::*;
#(
    parameter int          TW         = 8,
    parameter int          DEF_LOW    = 24,
    parameter int          DEF_PRES   = 6,
    parameter int          DEF_SHORT  = 3,
    parameter int unsigned FAST_SHIFT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_code,
    output logic          cmd_ack,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [TW-1:0] cfg_wdata,
    output logic [7:0]    status,
    output logic [3:0]    mode_o,
    output logic [TW-1:0] t_low_o,
    output logic [TW-1:0] t_pres_o,
    output logic [TW-1:0] t_short_o,
    output logic          line_drive_low,
    output logic          line_pu,
    input  logic          line_in
);
    act_e    act;
    mode_t   mode;
    status_t st;
    logic    busy, pres_stb, short_stb;

    owm_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .busy      (busy),
        .act       (act)
    );

    owm_cfg_regs #(
        .TW(TW), .DEF_LOW(DEF_LOW), .DEF_PRES(DEF_PRES), .DEF_SHORT(DEF_SHORT)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .clr     (act == ACT_MRST),
        .busy    (busy),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .mode    (mode),
        .t_low   (t_low_o),
        .t_pres  (t_pres_o),
        .t_short (t_short_o)
    );

    owm_pulse_seq #(.TW(TW), .FAST_SHIFT(FAST_SHIFT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .abort     (act == ACT_MRST),
        .start     (act == ACT_PULSE),
        .fast      (mode.fast),
        .apu       (mode.apu),
        .t_low     (t_low_o),
        .t_pres    (t_pres_o),
        .t_short   (t_short_o),
        .busy      (busy),
        .drive_low (line_drive_low),
        .pu_en     (line_pu),
        .pres_stb  (pres_stb),
        .short_stb (short_stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_ack    <= 1'b0;
            st.rst_f   <= 1'b1;
            st.pres_f  <= 1'b0;
            st.short_f <= 1'b0;
        end else begin
            cmd_ack <= (act != ACT_NONE);
            case (act)
                ACT_MRST: begin
                    st.rst_f   <= 1'b1;
                    st.pres_f  <= 1'b0;
                    st.short_f <= 1'b0;
                end
                ACT_PULSE: st.rst_f <= 1'b0;
                default: begin
                    if (pres_stb)  st.pres_f  <= !line_in;
                    if (short_stb) st.short_f <= !line_in;
                end
            endcase
        end
    end

    assign st.rsv  = '0;
    assign st.busy = busy;
    assign status  = st;
    assign mode_o  = mode;
endmodule

// File: rtl/owm_rstpd_chk.sv
module owm_rstpd_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [7:0] cmd_code,
    input logic       cmd_ack,
    input logic [7:0] status,
    input logic [3:0] mode,
    input logic       line_drive_low,
    input logic       line_pu
);
    assert_mrst_effect_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 8'hF0) |=>
            (cmd_ack && status == 8'h08 && mode == 4'h0 && !line_drive_low && !line_pu));

    assert_start_acked_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> (cmd_ack && !status[3]));

    assert_drive_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
        line_drive_low |-> status[0]);

    assert_busy_refuse_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 8'hB4 && status[0]) |=> !cmd_ack);

    assert_unknown_refuse_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code != 8'hF0 && cmd_code != 8'hB4) |=> !cmd_ack);

    assert_pu_after_low_R11: assert property (@(posedge clk) disable iff (rst)
        line_pu |-> (status[0] && !line_drive_low));
endmodule

bind owm_rstpd_ctrl owm_rstpd_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid      (cmd_valid),
    .cmd_code       (cmd_code),
    .cmd_ack        (cmd_ack),
    .status         (status),
    .mode           (mode_o),
    .line_drive_low (line_drive_low),
    .line_pu        (line_pu)
);

// File: tb/tb_owm_rstpd_ctrl.sv
module tb_owm_rstpd_ctrl;
    localparam int TW = 8, DL = 24, DP = 6, DS = 3, FS = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic          cmd_ack;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [TW-1:0] cfg_wdata = '0;
    logic [7:0]    status;
    logic [3:0]    mode_o;
    logic [TW-1:0] t_low_o, t_pres_o, t_short_o;
    logic          line_drive_low, line_pu, line_in;
    logic          dev_pull = 1'b0;

    assign line_in = !(line_drive_low || dev_pull);

    owm_rstpd_ctrl #(.TW(TW), .DEF_LOW(DL), .DEF_PRES(DP), .DEF_SHORT(DS), .FAST_SHIFT(FS)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_ack(cmd_ack),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .status(status),
        .mode_o(mode_o), .t_low_o(t_low_o), .t_pres_o(t_pres_o), .t_short_o(t_short_o),
        .line_drive_low(line_drive_low), .line_pu(line_pu), .line_in(line_in)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int cur_tlow = DL, cur_tpres = DP, cur_tshort = DS;
    logic [3:0] cur_mode = 4'h0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int t, input bit fast);
        int v;
        v = fast ? (t >> FS) : t;
        return (v == 0) ? 1 : v;
    endfunction

    task automatic cfg_write(input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = TW'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        case (addr)
            0: cur_mode = 4'(data);
            1: cur_tlow = data;
            2: cur_tpres = data;
            default: cur_tshort = data;
        endcase
    endtask

    // inj_kind: 0 none, 1 B4 while busy, 2 F0 abort, 3 unknown code, 4 config write while busy
    task automatic run_pulse(input int wa, input int wb, input int inj_j, input int inj_kind);
        int L, P, S;
        bit apu, ep, es;
        L = eff(cur_tlow, cur_mode[0]);
        P = eff(cur_tpres, cur_mode[0]);
        S = eff(cur_tshort, cur_mode[0]);
        apu = cur_mode[1];
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 8'hB4; dev_pull = 1'b0;
        for (int j = 1; j <= 2 * L + 1; j++) begin
            @(negedge clk);
            cmd_valid = 1'b0; cfg_we = 1'b0;
            if (j == 1) chk(cmd_ack == 1'b1, "R3 ack of accepted B4", int'(cmd_ack), 1);
            else if (j == inj_j + 1 && inj_kind == 2) begin
                chk(cmd_ack == 1'b1, "R2 ack of F0 during busy", int'(cmd_ack), 1);
                chk(status == 8'h08, "R2 status after abort", int'(status), 8);
                chk(line_drive_low == 1'b0 && line_pu == 1'b0, "R2 line released", int'(line_drive_low), 0);
                chk(mode_o == 4'h0 && t_low_o == TW'(DL) && t_pres_o == TW'(DP) && t_short_o == TW'(DS),
                    "R2 config restored", int'(t_low_o), DL);
                cur_mode = 4'h0; cur_tlow = DL; cur_tpres = DP; cur_tshort = DS;
                dev_pull = 1'b0;
                return;
            end else if (j == inj_j + 1)
                chk(cmd_ack == 1'b0, (inj_kind == 1) ? "R7 B4 while busy not acked" : "R8 unknown not acked",
                    int'(cmd_ack), 0);
            chk(status[0] == (j <= 2 * L), "R3 busy window", int'(status[0]), int'(j <= 2 * L));
            chk(line_drive_low == (j <= L), "R4 drive low window", int'(line_drive_low), int'(j <= L));
            chk(line_pu == (apu && j > L && j <= 2 * L), "R11 pull-up window", int'(line_pu),
                int'(apu && j > L && j <= 2 * L));
            dev_pull = (j >= wa && j < wb);
            if (j == inj_j) begin
                case (inj_kind)
                    1: begin cmd_valid = 1'b1; cmd_code = 8'hB4; end
                    2: begin cmd_valid = 1'b1; cmd_code = 8'hF0; end
                    3: begin cmd_valid = 1'b1; cmd_code = 8'h5A; end
                    4: begin cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = TW'(8'hFF); end
                    default: ;
                endcase
            end
        end
        dev_pull = 1'b0;
        ep = (L + P >= wa) && (L + P < wb);
        es = (L + S >= wa) && (L + S < wb);
        chk(status[1] == ep, "R5 presence flag", int'(status[1]), int'(ep));
        chk(status[2] == es, "R6 short flag", int'(status[2]), int'(es));
        chk(status[3] == 1'b0, "R3 reset flag cleared", int'(status[3]), 0);
        if (inj_kind == 4)
            chk(int'(t_low_o) == cur_tlow, "R9 write ignored while busy", int'(t_low_o), cur_tlow);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int L, P, S;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(status == 8'h08, "R1 reset status", int'(status), 8);
        chk(mode_o == 4'h0 && !line_drive_low && !line_pu, "R1 mode and line", int'(mode_o), 0);
        chk(t_low_o == TW'(DL) && t_pres_o == TW'(DP) && t_short_o == TW'(DS), "R1 timing defaults",
            int'(t_low_o), DL);

        // R8 at idle
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'h33;
        @(negedge clk); cmd_valid = 1'b0;
        chk(cmd_ack == 1'b0 && status == 8'h08, "R8 unknown at idle", int'(status), 8);

        // R9 write and read back
        cfg_write(1, 20); cfg_write(2, 5); cfg_write(3, 3);
        chk(t_low_o == 8'd20 && t_pres_o == 8'd5 && t_short_o == 8'd3, "R9 readback", int'(t_low_o), 20);

        run_pulse(22, 30, 0, 0);   // both samples low
        run_pulse(0, 0, 0, 0);     // no device
        run_pulse(24, 26, 0, 0);   // presence edge 25 inside, short edge 23 outside
        run_pulse(26, 30, 0, 0);   // window starts just after presence instant
        run_pulse(23, 25, 0, 0);   // window ends just before presence instant
        run_pulse(22, 30, 5, 1);   // R7
        run_pulse(22, 30, 7, 3);   // R8
        run_pulse(0, 0, 3, 4);     // R9 during busy

        // R10 fast mode with R11 pull-up
        cfg_write(1, 40); cfg_write(2, 12); cfg_write(3, 8); cfg_write(0, 4'b0011);
        chk(mode_o == 4'b0011, "R9 mode readback", int'(mode_o), 3);
        run_pulse(12, 14, 0, 0);   // R10: L=10 P=3 S=2 -> presence at 13, short at 12
        run_pulse(0, 0, 8, 2);     // R2 abort

        // R2 again from idle after fresh pulse
        @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'hF0;
        @(negedge clk); cmd_valid = 1'b0;
        chk(cmd_ack == 1'b1 && status == 8'h08, "R2 idle master reset", int'(status), 8);

        // random mix
        for (int n = 0; n < 30; n++) begin
            int a, w;
            L = 4 + int'($urandom % 37);
            P = 1 + int'($urandom % (L - 1));
            S = 1 + int'($urandom % (L - 1));
            cfg_write(1, L); cfg_write(2, P); cfg_write(3, S);
            cfg_write(0, int'($urandom % 16) & 4'b1110);
            a = L + 1 + int'($urandom % L);
            w = int'($urandom % 6);
            run_pulse(a, a + w, ((n % 5) == 0) ? 2 : 0, ((n % 5) == 0) ? 1 : 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule